// File: doc/BRIEF.md
# Key Matrix Snapshot Readout Register

This block holds a 25-bit picture of a 5-by-5 grid of key switches and hands it to a host through an 8-bit data register. The host reads the register five times in a row. Each byte it gets carries a 3-bit slice index in its upper bits and five switch levels in its lower bits. The index moves forward after every read and wraps to zero after the fifth one, so the host can always tell which part of the grid a byte belongs to.

The switch levels arrive already debounced. They are copied into an internal snapshot on every clock while the slice index is zero and no read strobe is high. Once a read sequence starts, the snapshot is frozen until the index returns to zero, so all five bytes of one sequence come from the same instant. A read is the rising edge of the strobe. A strobe held high for many cycles counts as one read.

Top module: `keyscan_readout`

## Requirements
- R1: The output byte carries the slice index in bits 7:5 and the five switch levels of the selected slice in bits 4:0.
- R2: With index n (0..4), output bit k (0..4) equals the snapshot copy of `sw_i[5*n+k]`, where 1 means the key is closed and 0 means it is open.
- R3: A read is counted on the first clock edge at which `rd_strb_i` is sampled high after being sampled low. That edge raises the index by one, and the new byte is visible right after it.
- R4: A read counted at index 4 returns the index to 0.
- R5: Keeping `rd_strb_i` high for further cycles counts no further reads, and the index stays unchanged until the strobe has been sampled low and then high again.
- R6: On each clock edge at which the index is 0 and `rd_strb_i` is low, the snapshot takes the present `sw_i`. After that edge the byte at index 0 shows `sw_i[4:0]` as it was sampled.
- R7: While the index is non-zero, or while `rd_strb_i` is high, changes on `sw_i` do not alter the output byte.
- R8: While `rst_ni` is low the output is 8'h00 (index 0, data 0), whatever `sw_i` and `rd_strb_i` are, and this holds at once without waiting for a clock.
- R9: The index never takes the values 5 to 7. If such a value were ever present, the next read would return the index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_strb_i | input | 1 | Host read strobe; its rising edge counts one read |
| sw_i | input | 25 | Debounced switch levels, bit 5*n+k is switch (n,k), 1 = closed |
| reg_o | output | 8 | Register value: slice index in 7:5, slice data in 4:0 |

## Verification
The hardest situation to reach is the freeze window. A switch change that lands while the index is non-zero, or while the strobe is held at index 0, must leave no trace in any byte of the sequence. A change that lands on the edge where the index has just wrapped to zero must show up in the next sequence. The stimulus flips the whole switch vector in the middle of a sequence and while a long strobe is held at index 0. It then runs random strobe patterns with the switches changing every cycle, so that wraps, held strobes and reloads line up in many orders. A behavioural model of the snapshot and index is compared with the byte on every cycle.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

   // How the slice index returns to zero
   typedef enum logic {
      KS_WRAP_NATURAL = 1'b0,   // group count fills the index width exactly
      KS_WRAP_COMPARE = 1'b1    // explicit compare against the last group
   } ks_wrap_e;

   function automatic ks_wrap_e ks_pick_wrap(input int unsigned groups,
                                             input int unsigned cnt_w);
      return (groups == (32'd1 << cnt_w)) ? KS_WRAP_NATURAL : KS_WRAP_COMPARE;
   endfunction

endpackage

// File: rtl/ks_edge_detect.sv
module ks_edge_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/ks_slice_counter.sv
module ks_slice_counter
   import keyscan_pkg::*;
#(
   parameter int unsigned GROUPS = 5,
   parameter int unsigned CNT_W  = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_zero_o
);
   localparam ks_wrap_e         WRAP = ks_pick_wrap(GROUPS, CNT_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;

   generate
      if (WRAP == KS_WRAP_NATURAL) begin : g_natural
         assign cnt_nxt = cnt_q + 1'b1;
      end else begin : g_compare
         // any value at or past the last group goes back to zero
         assign cnt_nxt = (cnt_q >= LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_nxt;
   end

   assign cnt_o     = cnt_q;
   assign at_zero_o = (cnt_q == '0);
endmodule

// File: rtl/ks_snapshot.sv
module ks_snapshot #(
   parameter int unsigned WIDTH = 25
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (load_i) q <= d_i;
   end

   assign q_o = q;
endmodule

// File: rtl/ks_slice_mux.sv
module ks_slice_mux #(
   parameter int unsigned GROUPS     = 5,
   parameter int unsigned GROUP_BITS = 5,
   parameter int unsigned CNT_W      = 3
) (
   input  logic [CNT_W-1:0]             sel_i,
   input  logic [GROUPS*GROUP_BITS-1:0] snap_i,
   output logic [GROUP_BITS-1:0]        data_o
);
   logic [GROUP_BITS-1:0] slice [GROUPS];
   logic [GROUPS-1:0]     hit;

   for (genvar g = 0; g < GROUPS; g++) begin : g_slice
      assign slice[g] = snap_i[g*GROUP_BITS +: GROUP_BITS];
      assign hit[g]   = (sel_i == CNT_W'(g));
   end

   // an index outside the group range selects nothing
   always_comb begin
      data_o = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (hit[g]) data_o = slice[g];
      end
   end
endmodule

// File: rtl/keyscan_readout.sv
module keyscan_readout #(
   parameter int unsigned GROUPS     = 5,
   parameter int unsigned GROUP_BITS = 5,
   parameter int unsigned CNT_W      = 3,
   localparam int unsigned SW_W      = GROUPS * GROUP_BITS,
   localparam int unsigned REG_W     = CNT_W + GROUP_BITS
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rd_strb_i,
   input  logic [SW_W-1:0]  sw_i,
   output logic [REG_W-1:0] reg_o
);
   // elaboration-time parameter checks
   if (GROUPS < 2) begin : g_chk_groups
      $error("keyscan_readout: GROUPS must be at least 2");
   end
   if (GROUP_BITS < 1) begin : g_chk_bits
      $error("keyscan_readout: GROUP_BITS must be at least 1");
   end
   if ((32'd1 << CNT_W) < GROUPS) begin : g_chk_cnt
      $error("keyscan_readout: CNT_W too narrow for GROUPS");
   end

   logic                  rd_rise;
   logic                  idx_zero;
   logic [CNT_W-1:0]      idx;
   logic [SW_W-1:0]       snap;
   logic [GROUP_BITS-1:0] slice;

   ks_edge_detect u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (rd_strb_i),
      .rise_o (rd_rise)
   );

   ks_slice_counter #(.GROUPS(GROUPS), .CNT_W(CNT_W)) u_idx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (rd_rise),
      .cnt_o     (idx),
      .at_zero_o (idx_zero)
   );

   ks_snapshot #(.WIDTH(SW_W)) u_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (idx_zero & ~rd_strb_i),
      .d_i    (sw_i),
      .q_o    (snap)
   );

   ks_slice_mux #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS), .CNT_W(CNT_W)) u_mux (
      .sel_i  (idx),
      .snap_i (snap),
      .data_o (slice)
   );

   assign reg_o = {idx, slice};
endmodule

// File: rtl/keyscan_readout_chk.sv
module keyscan_readout_chk #(
   parameter int unsigned GROUPS     = 5,
   parameter int unsigned GROUP_BITS = 5,
   parameter int unsigned CNT_W      = 3,
   localparam int unsigned SW_W      = GROUPS * GROUP_BITS,
   localparam int unsigned REG_W     = CNT_W + GROUP_BITS
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rd_strb_i,
   input logic [SW_W-1:0]  sw_i,
   input logic [REG_W-1:0] reg_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

   logic             strb_prev;
   logic [CNT_W-1:0] idx;
   logic             rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strb_prev <= 1'b0;
      else         strb_prev <= rd_strb_i;
   end

   assign idx  = reg_o[REG_W-1 -: CNT_W];
   assign rise = rd_strb_i & ~strb_prev;

   // R3: a counted read below the last group steps the index by one
   a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && idx != LAST) |=> (idx == CNT_W'($past(idx) + 1'b1)));

   // R4: a counted read at the last group returns to zero
   a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && idx == LAST) |=> (idx == '0));

   // R5: without a fresh rising edge the index holds
   a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rise |=> $stable(idx));

   // R6: the index-0 byte follows the switches sampled at a load edge
   a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idx == '0 && !rd_strb_i) |=>
         (reg_o == {CNT_W'(0), $past(sw_i[GROUP_BITS-1:0])}));

   // R7: frozen snapshot, the byte does not move without a counted read
   a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rise && (idx != '0 || rd_strb_i)) |=> $stable(reg_o));

   // R9: index stays inside the group range
   a_r9_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx <= LAST);
endmodule

bind keyscan_readout keyscan_readout_chk #(
   .GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS), .CNT_W(CNT_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .rd_strb_i (rd_strb_i),
   .sw_i      (sw_i),
   .reg_o     (reg_o)
);

// File: tb/keyscan_readout_test.sv
`timescale 1ns/1ps
module keyscan_readout_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd = 1'b0;
   logic [24:0] sw = '0;
   logic [7:0]  reg_o;

   int n_checks = 0;
   int n_fail   = 0;
   string tag = "R8";

   always #2 clk = ~clk;   // 250 MHz

   keyscan_readout uut (
      .clk_i(clk), .rst_ni(rst_n), .rd_strb_i(rd), .sw_i(sw), .reg_o(reg_o)
   );

   // ---------------- behavioural reference ----------------
   int          m_idx = 0;
   logic [24:0] m_snap = '0;
   bit          m_prev = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_idx <= 0; m_snap <= '0; m_prev <= 0;
      end else begin
         if (m_idx == 0 && !rd) m_snap <= sw;
         if (rd && !m_prev) m_idx <= (m_idx + 1) % 5;
         m_prev <= rd;
      end
   end

   function automatic logic [7:0] expect_byte(int idx, logic [24:0] snap);
      logic [7:0] e;
      e[7:5] = 3'(idx);
      for (int k = 0; k < 5; k++) e[k] = snap[idx*5 + k];
      return e;
   endfunction

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison (R1 layout, R2 mapping via the model)
   always @(negedge clk) begin
      check((rst_n ? tag : "R8"), reg_o, rst_n ? expect_byte(m_idx, m_snap) : 8'h00);
   end

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic read_once();
      rd = 1'b1; step(); rd = 1'b0; step();
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   // ---------------- directed and random stimulus ----------------
   logic [24:0] pat;
   initial begin
      // R8: reset holds the byte at zero regardless of inputs
      sw = '1; rd = 1'b1;
      step(3);
      @(negedge clk); check("R8", reg_o, 8'h00);
      rd = 1'b0; step(); rst_n = 1'b1; tag = "R6";

      // R6 + R1 + R2: load a pattern, read five slices, R4 wrap
      pat = 25'h1A5_C3E9; sw = pat; step(2);
      @(negedge clk); check("R6", reg_o, {3'd0, pat[4:0]});
      tag = "R3";
      for (int n = 1; n < 5; n++) begin
         read_once();
         @(negedge clk); check("R3", reg_o, {3'(n), pat[n*5 +: 5]});
         if (n == 2) begin
            // R7: switch change in mid-sequence is not seen
            sw = ~pat; step(2);
            @(negedge clk); check("R7", reg_o, {3'd2, pat[14:10]});
         end
      end
      read_once();
      @(negedge clk); check("R4", reg_o[7:5], 8'(3'd0) | (reg_o & 8'h00));
      step();
      @(negedge clk); check("R6", reg_o, {3'd0, sw[4:0]});

      // R5: long strobe counts once; R7: frozen while strobe held at index 0
      tag = "R5";
      pat = 25'h0AB_5F21; sw = pat; step(2);
      rd = 1'b1; step();
      sw = ~pat; step(4);
      @(negedge clk); check("R5", reg_o, {3'd1, pat[9:5]});
      rd = 1'b0; step(2);
      @(negedge clk); check("R5", reg_o, {3'd1, pat[9:5]});
      for (int n = 2; n < 5; n++) read_once();
      read_once();
      @(negedge clk); check("R4", reg_o[7:5], 8'h00);

      // R2: walking one through every switch position
      tag = "R2";
      for (int b = 0; b < 25; b++) begin
         sw = 25'd1 << b; step(2);
         for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            check("R2", reg_o, {3'(n), ((n == b / 5) ? 5'(5'd1 << (b % 5)) : 5'd0)});
            read_once();
         end
      end

      // R8: reset in mid-sequence
      sw = 25'h155_5555; step(2);
      read_once(); read_once(); read_once();
      rst_n = 1'b0; #0.5;
      check("R8", reg_o, 8'h00);
      step(2); rst_n = 1'b1; tag = "R9";

      // R9/R3/R7: random strobes and switches, model compared each cycle
      for (int i = 0; i < 3000; i++) begin
         sw = 25'($urandom);
         rd = ($urandom % 3) == 0;
         step();
         @(negedge clk); check("R9", {5'd0, reg_o[7:5]} <= 8'd4 ? 8'd1 : 8'd0, 8'd1);
      end
      rd = 1'b0; step(2);
      report();
   end
endmodule